// File: doc/BRIEF.md
# Unaligned 128-Bit Load Combiner

This block serves a 16-byte load whose start address may fall on any byte. It takes one request at a time and reads whole aligned 16-byte lines from a synchronous memory port with one cycle of read latency. When the start address sits on a line boundary, one line is read and returned unchanged. When it does not, the block reads the line that holds the first byte and then the line after it. It keeps the first line, shifts the two lines together right by the byte offset, and returns the low 128 bits.

A request can ask for alignment checking. If it does and the address is not a multiple of 16, the block reads no memory and answers with an alignment fault. A misaligned address without the check is served normally and never faults. The byte order is little-endian: byte k of a 128-bit word sits in bits 8k+7 down to 8k. A response is valid for exactly one cycle and has no handshake. The request side shows a ready signal that is low while a load is in progress.

Top module: `uload_combiner`

## Requirements
- R1: After reset, req_ready_o is 1, and rsp_valid_o, rsp_fault_o and mem_rd_en_o are 0.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. req_ready_o is then 0 until the cycle after rsp_valid_o. While it is low, req_valid_i and req_addr_i are ignored.
- R3: For an address with addr[3:0] == 0, exactly one memory read is issued, at that address. rsp_valid_o is high in the second cycle after the accepting edge, and rsp_data_o holds the 16 bytes starting at the address.
- R4: For an address with addr[3:0] != 0, two reads are issued in consecutive cycles. The first is at addr & ~15 and the second at (addr & ~15) + 16. rsp_valid_o is high in the third cycle after the accepting edge, and byte k of rsp_data_o equals memory byte addr + k.
- R5: mem_rd_en_o is never high while req_ready_o is high, and every address issued with mem_rd_en_o has bits [3:0] equal to 0.
- R6: When req_acheck_i is 0, no address raises rsp_fault_o.
- R7: When req_acheck_i is 1 and addr[3:0] != 0, rsp_valid_o and rsp_fault_o are both 1 in the first cycle after the accepting edge. No memory read is issued, and rsp_data_o is 0.
- R8: When req_acheck_i is 1 and addr[3:0] == 0, the load behaves as in R3, with rsp_fault_o at 0.
- R9: rsp_valid_o is high for a single cycle per request. rsp_data_o is 0 whenever rsp_valid_o is 0 or rsp_fault_o is 1.
- R10: The second line address wraps modulo 2^ADDR_W, so a load near the top of the address space takes its upper bytes from address 0 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Byte address of the first byte |
| req_acheck_i | input | 1 | Fault on a misaligned address |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Aligned line address |
| mem_rdata_i | input | 8*LANE_BYTES | Line data, one cycle after the strobe |
| rsp_valid_o | output | 1 | Response present for one cycle |
| rsp_data_o | output | 8*LANE_BYTES | Assembled load data |
| rsp_fault_o | output | 1 | Alignment fault, no data |

## Verification
The hardest case to reach is a misaligned load whose second line crosses the top of the address space. It only happens with addresses in the last 15 bytes below 2^ADDR_W. The bench drives such an address directly and checks that the second read goes to line 0 and that the upper result bytes come from there. It also sweeps every byte offset inside a line to cover all shift amounts. It holds req_valid_i high with a different address throughout a busy load to show that the second request neither disturbs the data nor triggers extra reads.

// File: rtl/uload_pkg.sv
package uload_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ0 = 2'd1,
      ST_READ1 = 2'd2,
      ST_DONE  = 2'd3
   } uload_state_e;

endpackage

// File: rtl/uload_ctrl.sv
module uload_ctrl
   import uload_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LANE_BYTES = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid_i,
   input  logic [ADDR_W-1:0]                req_addr_i,
   input  logic                             req_acheck_i,
   output logic                             req_ready_o,
   output logic                             mem_rd_en_o,
   output logic [ADDR_W-1:0]                mem_addr_o,
   output logic                             cap_lo_o,
   output logic [$clog2(LANE_BYTES)-1:0]    off_o,
   output logic                             done_o,
   output logic                             fault_o
);
   localparam int OFF_W = $clog2(LANE_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANE_BYTES);

   uload_state_e      state_q, state_d;
   logic [ADDR_W-1:0] base_q;
   logic [OFF_W-1:0]  off_q;
   logic              fault_q;

   logic              accept;
   logic [OFF_W-1:0]  req_off;
   logic              req_trap;

   assign accept   = req_valid_i && (state_q == ST_IDLE);
   assign req_off  = req_addr_i[OFF_W-1:0];
   assign req_trap = req_acheck_i && (req_off != '0);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = req_trap ? ST_DONE : ST_READ0;
         ST_READ0: state_d = (off_q != '0) ? ST_READ1 : ST_DONE;
         ST_READ1: state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         off_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            base_q  <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            off_q   <= req_off;
            fault_q <= req_trap;
         end
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign mem_rd_en_o = (state_q == ST_READ0) || (state_q == ST_READ1);
   assign mem_addr_o  = (state_q == ST_READ1) ? base_q + STEP : base_q;
   assign cap_lo_o    = (state_q == ST_READ1);
   assign off_o       = off_q;
   assign done_o      = (state_q == ST_DONE);
   assign fault_o     = (state_q == ST_DONE) && fault_q;

endmodule

// File: rtl/uload_merge.sv
module uload_merge #(
   parameter int LANE_BYTES = 16,
   parameter bit LOG_SHIFT  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_lo_i,
   input  logic [$clog2(LANE_BYTES)-1:0] off_i,
   input  logic                          emit_i,
   input  logic [8*LANE_BYTES-1:0]       mem_rdata_i,
   output logic [8*LANE_BYTES-1:0]       data_o
);
   localparam int OFF_W  = $clog2(LANE_BYTES);
   localparam int DATA_W = 8 * LANE_BYTES;

   logic [DATA_W-1:0]   lo_q;
   logic [2*DATA_W-1:0] cat;
   logic [DATA_W-1:0]   shifted;
   logic [DATA_W-1:0]   picked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lo_q <= '0;
      else if (cap_lo_i) lo_q <= mem_rdata_i;
   end

   assign cat = {mem_rdata_i, lo_q};

   generate
      if (LOG_SHIFT) begin : g_log
         logic [2*DATA_W-1:0] stg [0:OFF_W];
         assign stg[0] = cat;
         for (genvar k = 0; k < OFF_W; k++) begin : g_stage
            assign stg[k+1] = off_i[k] ? (stg[k] >> (8 * (1 << k))) : stg[k];
         end
         assign shifted = stg[OFF_W][DATA_W-1:0];
      end else begin : g_mux
         always_comb begin
            shifted = cat[DATA_W-1:0];
            for (int j = 1; j < LANE_BYTES; j++) begin
               if (off_i == OFF_W'(j)) shifted = cat[8*j +: DATA_W];
            end
         end
      end
   endgenerate

   assign picked = (off_i == '0) ? mem_rdata_i : shifted;
   assign data_o = emit_i ? picked : '0;

endmodule

// File: rtl/uload_combiner.sv
module uload_combiner #(
   parameter int ADDR_W     = 32,
   parameter int LANE_BYTES = 16,
   parameter bit LOG_SHIFT  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid_i,
   output logic                      req_ready_o,
   input  logic [ADDR_W-1:0]         req_addr_i,
   input  logic                      req_acheck_i,
   output logic                      mem_rd_en_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   input  logic [8*LANE_BYTES-1:0]   mem_rdata_i,
   output logic                      rsp_valid_o,
   output logic [8*LANE_BYTES-1:0]   rsp_data_o,
   output logic                      rsp_fault_o
);
   localparam int OFF_W = $clog2(LANE_BYTES);

   generate
      if (LANE_BYTES < 2 || (LANE_BYTES & (LANE_BYTES - 1)) != 0) begin : g_bad_lane
         $error("LANE_BYTES must be a power of two of at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W must exceed the line offset width");
      end
   endgenerate

   logic             cap_lo;
   logic [OFF_W-1:0] off;
   logic             done;
   logic             fault;

   uload_ctrl #(
      .ADDR_W     (ADDR_W),
      .LANE_BYTES (LANE_BYTES)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_addr_i   (req_addr_i),
      .req_acheck_i (req_acheck_i),
      .req_ready_o  (req_ready_o),
      .mem_rd_en_o  (mem_rd_en_o),
      .mem_addr_o   (mem_addr_o),
      .cap_lo_o     (cap_lo),
      .off_o        (off),
      .done_o       (done),
      .fault_o      (fault)
   );

   uload_merge #(
      .LANE_BYTES (LANE_BYTES),
      .LOG_SHIFT  (LOG_SHIFT)
   ) u_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_lo_i    (cap_lo),
      .off_i       (off),
      .emit_i      (done && !fault),
      .mem_rdata_i (mem_rdata_i),
      .data_o      (rsp_data_o)
   );

   assign rsp_valid_o = done;
   assign rsp_fault_o = fault;

endmodule

// File: rtl/uload_chk.sv
module uload_chk #(
   parameter int ADDR_W     = 32,
   parameter int LANE_BYTES = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid_i,
   input logic                    req_ready_o,
   input logic [ADDR_W-1:0]       req_addr_i,
   input logic                    req_acheck_i,
   input logic                    mem_rd_en_o,
   input logic [ADDR_W-1:0]       mem_addr_o,
   input logic                    rsp_valid_o,
   input logic [8*LANE_BYTES-1:0] rsp_data_o,
   input logic                    rsp_fault_o
);
   localparam int OFF_W = $clog2(LANE_BYTES);

   logic acc;
   logic mis;
   assign acc = req_valid_i && req_ready_o;
   assign mis = (req_addr_i[OFF_W-1:0] != '0);

   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !req_ready_o);

   assert_ready_after_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |=> req_ready_o);

   assert_line_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en_o |-> (mem_addr_o[OFF_W-1:0] == '0));

   assert_no_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> !mem_rd_en_o);

   assert_fast_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_acheck_i && mis) |=> (rsp_valid_o && rsp_fault_o && !mem_rd_en_o));

   assert_first_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !(req_acheck_i && mis)) |=>
         (mem_rd_en_o && !rsp_valid_o &&
          mem_addr_o == {$past(req_addr_i[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |=> !rsp_valid_o);

   assert_quiet_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_valid_o || rsp_fault_o) |-> (rsp_data_o == '0));

   assert_fault_in_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault_o |-> rsp_valid_o);

endmodule

bind uload_combiner uload_chk #(
   .ADDR_W     (ADDR_W),
   .LANE_BYTES (LANE_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid_i  (req_valid_i),
   .req_ready_o  (req_ready_o),
   .req_addr_i   (req_addr_i),
   .req_acheck_i (req_acheck_i),
   .mem_rd_en_o  (mem_rd_en_o),
   .mem_addr_o   (mem_addr_o),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_data_o   (rsp_data_o),
   .rsp_fault_o  (rsp_fault_o)
);

// File: tb/uload_combiner_test.sv
module uload_combiner_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid_i = 1'b0;
   logic         req_ready_o;
   logic [31:0]  req_addr_i = '0;
   logic         req_acheck_i = 1'b0;
   logic         mem_rd_en_o;
   logic [31:0]  mem_addr_o;
   logic [127:0] mem_rdata_i = '0;
   logic         rsp_valid_o;
   logic [127:0] rsp_data_o;
   logic         rsp_fault_o;

   int total = 0;
   int bad   = 0;
   int rd_total = 0;
   logic [31:0] rd_log [0:7];

   always #(CLK_PERIOD/2) clk = ~clk;

   uload_combiner uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_ready_o  (req_ready_o),
      .req_addr_i   (req_addr_i),
      .req_acheck_i (req_acheck_i),
      .mem_rd_en_o  (mem_rd_en_o),
      .mem_addr_o   (mem_addr_o),
      .mem_rdata_i  (mem_rdata_i),
      .rsp_valid_o  (rsp_valid_o),
      .rsp_data_o   (rsp_data_o),
      .rsp_fault_o  (rsp_fault_o)
   );

   function automatic logic [7:0] byte_at(logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ a[31:24] ^ 8'h5A;
   endfunction

   function automatic logic [127:0] bytes_from(logic [31:0] a);
      logic [127:0] r;
      for (int i = 0; i < 16; i++) r[8*i +: 8] = byte_at(a + 32'(i));
      return r;
   endfunction

   // memory model: one cycle read latency, plus a log of issued reads
   always @(posedge clk) begin
      if (rst_n && mem_rd_en_o) begin
         mem_rdata_i <= bytes_from(mem_addr_o);
         rd_log[rd_total[2:0]] <= mem_addr_o;
         rd_total <= rd_total + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // one load; hold_other keeps a second request asserted while busy
   task automatic run_load(input logic [31:0] a, input logic ac, input bit hold_other);
      bit       mis = (a[3:0] != 4'h0);
      bit       exp_fault = ac && mis;
      int       exp_lat = exp_fault ? 1 : (mis ? 3 : 2);
      int       exp_rd  = exp_fault ? 0 : (mis ? 2 : 1);
      logic [31:0]  base = {a[31:4], 4'h0};
      logic [127:0] exp_data = exp_fault ? 128'h0 : bytes_from(a);
      int       start;
      int       lat;
      @(negedge clk);
      chk(req_ready_o == 1'b1, "R2 ready before request", 128'(req_ready_o), 128'h1);
      start = rd_total;
      req_valid_i  = 1'b1;
      req_addr_i   = a;
      req_acheck_i = ac;
      @(negedge clk);
      if (hold_other) begin
         req_addr_i   = a ^ 32'h0000_1234;
         req_acheck_i = 1'b0;
      end else begin
         req_valid_i = 1'b0;
      end
      lat = 1;
      if (!rsp_valid_o)
         chk(rsp_data_o == 128'h0, "R9 data zero while not valid", rsp_data_o, 128'h0);
      while (!rsp_valid_o && lat < 8) begin
         @(negedge clk);
         lat++;
      end
      req_valid_i = 1'b0;
      chk(lat == exp_lat, exp_fault ? "R7 fault latency" : (mis ? "R4 latency" : "R3 latency"),
          128'(lat), 128'(exp_lat));
      chk(rsp_fault_o == exp_fault, exp_fault ? "R7 fault flag" : (ac ? "R8 no fault" : "R6 no fault"),
          128'(rsp_fault_o), 128'(exp_fault));
      chk(rsp_data_o == exp_data, exp_fault ? "R7 data zero" : (mis ? "R4 merged data" : "R3 data"),
          rsp_data_o, exp_data);
      chk(req_ready_o == 1'b0, "R2 busy during response", 128'(req_ready_o), 128'h0);
      chk(rd_total - start == exp_rd, hold_other ? "R2 held request ignored" : "R3/R4 read count",
          128'(rd_total - start), 128'(exp_rd));
      if (exp_rd >= 1)
         chk(rd_log[start[2:0]] == base, "R4 first line address",
             128'(rd_log[start[2:0]]), 128'(base));
      if (exp_rd == 2)
         chk(rd_log[3'(start + 1)] == base + 32'd16, "R10 second line address",
             128'(rd_log[3'(start + 1)]), 128'(base + 32'd16));
      @(negedge clk);
      chk(rsp_valid_o == 1'b0 && rsp_data_o == 128'h0, "R9 single pulse, data cleared",
          {rsp_valid_o, rsp_data_o[126:0]}, 128'h0);
      chk(req_ready_o == 1'b1, "R2 ready after response", 128'(req_ready_o), 128'h1);
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(req_ready_o == 1'b1, "R1 ready in reset", 128'(req_ready_o), 128'h1);
      chk(!rsp_valid_o && !rsp_fault_o && !mem_rd_en_o, "R1 quiet outputs",
          {125'h0, rsp_valid_o, rsp_fault_o, mem_rd_en_o}, 128'h0);
   endtask

   task automatic test_aligned();
      run_load(32'h0000_1000, 1'b0, 1'b0);
      run_load(32'hABCD_EF30, 1'b1, 1'b0);
   endtask

   task automatic test_offsets();
      for (int k = 1; k < 16; k++) run_load(32'h0000_2040 + 32'(k), 1'b0, 1'b0);
   endtask

   task automatic test_fault();
      run_load(32'h0000_3007, 1'b1, 1'b0);
      run_load(32'h0000_300F, 1'b1, 1'b0);
   endtask

   task automatic test_wrap();
      run_load(32'hFFFF_FFF5, 1'b0, 1'b0);
      run_load(32'hFFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic test_busy_hold();
      run_load(32'h0000_4449, 1'b0, 1'b1);
      run_load(32'h0000_5550, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (2) @(negedge clk);
      test_reset();
      @(negedge clk);
      rst_n = 1'b1;
      test_aligned();
      test_offsets();
      test_fault();
      test_wrap();
      test_busy_hold();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule